// File: doc/BRIEF.md
# Half-step prescaler baud rate generator

This block turns the system clock into the timing enables a serial port needs. Software loads two 8-bit registers: a prescale register and a divisor register. The top five bits of the prescale register choose a prescale factor from 1 to 16 in steps of one half, measured in units of the half-rate clock. The remaining three bits join the divisor register to form an 11-bit divisor field. The generator has three stages, each a plain counter in the input clock domain. A prescaler divides the input clock by (code + 1) cycles. A divisor stage then divides by (field + 1) and gives the 16x sample tick. An oversampling stage divides that by 16 and gives the bit tick. The resulting bit rate is the input clock divided by 32 × N × P. For example, with a 20 MHz clock, the word 0x0800 gives 625 kbaud and 0xC804 gives about 9615 baud.

A prescale code of zero puts the block in a legacy compatibility mode. In that mode the generator is idle, and an external divider is expected to supply the rate. In synchronous mode the oversampling stage is bypassed, so the bit tick follows the sample tick. Every tick is a one-cycle enable, not a derived clock. The block has no streaming data path. Its register writes and mode input are plain control pins with no back-pressure.

Top module: `halfstep_baud_gen`

## Requirements
- R1: After reset, compat_mode is 1 and sample_tick and bit_tick are 0.
- R2: When the prescale code (psr_data[7:3] as last written) is 0, compat_mode is 1 and neither tick ever asserts. A divisor write made in this mode is still stored.
- R3: A PSR write with a nonzero prescale code clears compat_mode from the next cycle.
- R4: With prescale code C (1..31) and divisor field D = {psr[2:0], baud[7:0]} (0..2047), sample_tick pulses once every (C+1)·(D+1) clock cycles.
- R5: In asynchronous mode (sync_mode = 0), bit_tick pulses on every 16th sample_tick, so once every 16·(C+1)·(D+1) cycles.
- R6: In synchronous mode (sync_mode = 1), bit_tick equals sample_tick in every cycle.
- R7: A write to either register restarts all counters. The first sample_tick then falls in the (C+1)·(D+1)-th cycle after the write edge, and none falls in the cycle right after it.
- R8: sample_tick is never high in two consecutive cycles.
- R9: bit_tick is only ever high together with sample_tick.
- R10: The word 0xC804 (C = 25, D = 4) gives a sample period of 130 cycles and a bit period of 2080 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psr_wr | input | 1 | Write strobe for the prescale register |
| psr_data | input | 8 | Prescale code [7:3] and divisor high bits [2:0] |
| baud_wr | input | 1 | Write strobe for the divisor low byte |
| baud_data | input | 8 | Divisor field bits [7:0] |
| sync_mode | input | 1 | 1 = synchronous (no divide by 16), 0 = asynchronous |
| sample_tick | output | 1 | One-cycle 16x sample enable |
| bit_tick | output | 1 | One-cycle bit-rate enable |
| compat_mode | output | 1 | High while the prescale code is zero |

## Verification
A wrong count limit or a stuck counter in any stage shows up as a wrong tick interval. It becomes visible within one sample period for the prescaler and divisor, and within sixteen for the oversampler. That is why every setting is checked for the position of its first and second sample ticks and its first bit tick, counted from the last write. A counter that is not cleared on a write shows up as a shifted first tick right after a mid-period rewrite. A compatibility flag that is decoded wrongly shows up as ticks appearing while the code is zero, or as a missing exit on the next write.

// File: rtl/brg_pkg.sv
package brg_pkg;
  parameter int unsigned BRG_REG_W = 8;
  parameter int unsigned BRG_PRE_W = 5;
  parameter int unsigned BRG_DIV_W = 11;
  parameter int unsigned BRG_OVS_LOG2 = 4;

  typedef struct packed {
    logic [BRG_PRE_W-1:0] pre_code;
    logic [BRG_DIV_W-1:0] div_last;
  } brg_cfg_t;
endpackage

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs
  import brg_pkg::*;
#(
  parameter int unsigned REG_W = BRG_REG_W,
  parameter int unsigned PRE_W = BRG_PRE_W,
  parameter int unsigned DIV_W = BRG_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psr_wr,
  input  logic [REG_W-1:0] psr_data,
  input  logic             baud_wr,
  input  logic [REG_W-1:0] baud_data,
  output brg_cfg_t         cfg,
  output logic             idle,
  output logic             restart
);
  localparam int unsigned HI_W = DIV_W - REG_W;

  logic [REG_W-1:0] psr_q;
  logic [REG_W-1:0] baud_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr_q  <= '0;
      baud_q <= '0;
    end else begin
      if (psr_wr)  psr_q  <= psr_data;
      if (baud_wr) baud_q <= baud_data;
    end
  end

  assign cfg.pre_code = psr_q[REG_W-1 -: PRE_W];
  assign cfg.div_last = {psr_q[HI_W-1:0], baud_q};
  assign idle         = (cfg.pre_code == '0);
  assign restart      = psr_wr | baud_wr;
endmodule

// File: rtl/brg_stage.sv
module brg_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic         fire
);
  logic [W-1:0] cnt;

  assign fire = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (en)   cnt <= fire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/halfstep_baud_gen.sv
module halfstep_baud_gen
  import brg_pkg::*;
#(
  parameter int unsigned REG_W    = BRG_REG_W,
  parameter int unsigned PRE_W    = BRG_PRE_W,
  parameter int unsigned DIV_W    = BRG_DIV_W,
  parameter int unsigned OVS_LOG2 = BRG_OVS_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psr_wr,
  input  logic [REG_W-1:0] psr_data,
  input  logic             baud_wr,
  input  logic [REG_W-1:0] baud_data,
  input  logic             sync_mode,
  output logic             sample_tick,
  output logic             bit_tick,
  output logic             compat_mode
);
  localparam logic [OVS_LOG2-1:0] OVS_LAST = '1;

  brg_cfg_t cfg;
  logic     idle;
  logic     restart;
  logic     pre_fire;
  logic     div_fire;
  logic     ovs_fire;

  brg_cfg_regs #(.REG_W(REG_W), .PRE_W(PRE_W), .DIV_W(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .psr_wr    (psr_wr),
    .psr_data  (psr_data),
    .baud_wr   (baud_wr),
    .baud_data (baud_data),
    .cfg       (cfg),
    .idle      (idle),
    .restart   (restart)
  );

  // Stage 1: half-step prescaler, (code+1) input clocks per pulse
  brg_stage #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .en    (!idle),
    .last  (cfg.pre_code),
    .fire  (pre_fire)
  );

  // Stage 2: divisor, (field+1) prescaler pulses per sample tick
  brg_stage #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .en    (pre_fire),
    .last  (cfg.div_last),
    .fire  (div_fire)
  );

  // Stage 3: oversampling divide by 2**OVS_LOG2
  brg_stage #(.W(OVS_LOG2)) u_ovs (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .en    (div_fire),
    .last  (OVS_LAST),
    .fire  (ovs_fire)
  );

  assign sample_tick = div_fire;
  assign bit_tick    = sync_mode ? div_fire : ovs_fire;
  assign compat_mode = idle;
endmodule

// File: rtl/halfstep_baud_gen_chk.sv
module halfstep_baud_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       psr_wr,
  input logic [4:0] pre_field,
  input logic       baud_wr,
  input logic       sync_mode,
  input logic       sample_tick,
  input logic       bit_tick,
  input logic       compat_mode
);
  AST_COMPAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    compat_mode |-> (!sample_tick && !bit_tick)); // R2
  AST_COMPAT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr && pre_field == 5'd0) |=> compat_mode); // R2
  AST_COMPAT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr && pre_field != 5'd0) |=> !compat_mode); // R3
  AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> (bit_tick == sample_tick)); // R6
  AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr || baud_wr) |=> !sample_tick); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick); // R8
  AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R9
endmodule

bind halfstep_baud_gen halfstep_baud_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .psr_wr      (psr_wr),
  .pre_field   (psr_data[7:3]),
  .baud_wr     (baud_wr),
  .sync_mode   (sync_mode),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick),
  .compat_mode (compat_mode)
);

// File: tb/halfstep_baud_gen_bench.sv
module halfstep_baud_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {psr[7:0], baud[7:0], sync, expected sample period[15:0]}
  localparam logic [32:0] VECS [NVEC] = '{
    {8'h08, 8'h00, 1'b0, 16'd2},
    {8'hC8, 8'h04, 1'b0, 16'd130},
    {8'h10, 8'h02, 1'b0, 16'd9},
    {8'h18, 8'h01, 1'b1, 16'd8},
    {8'hF8, 8'h00, 1'b0, 16'd32},
    {8'h09, 8'hFF, 1'b1, 16'd1024},
    {8'h0F, 8'hFF, 1'b1, 16'd4096}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psr_wr = 1'b0;
  logic [7:0] psr_data = '0;
  logic baud_wr = 1'b0;
  logic [7:0] baud_data = '0;
  logic sync_mode = 1'b0;
  logic sample_tick, bit_tick, compat_mode;
  int checks = 0;
  int errors = 0;
  int f1, f2, b1;

  halfstep_baud_gen u_halfstep_baud_gen (
    .clk(clk), .rst_n(rst_n), .psr_wr(psr_wr), .psr_data(psr_data),
    .baud_wr(baud_wr), .baud_data(baud_data), .sync_mode(sync_mode),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .compat_mode(compat_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_psr(input logic [7:0] v);
    @(negedge clk); psr_wr = 1'b1; psr_data = v;
    @(negedge clk); psr_wr = 1'b0;
  endtask

  task automatic wr_baud(input logic [7:0] v);
    @(negedge clk); baud_wr = 1'b1; baud_data = v;
    @(negedge clk); baud_wr = 1'b0;
  endtask

  // Called at the first negedge after a write edge; n counts those negedges
  task automatic measure(input int lim);
    f1 = 0; f2 = 0; b1 = 0;
    for (int n = 1; n <= lim; n++) begin
      if (sample_tick && f1 == 0) f1 = n;
      else if (sample_tick && f2 == 0) f2 = n;
      if (bit_tick && b1 == 0) b1 = n;
      if (n < lim) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sp, bp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 compat", int'(compat_mode), 1);
    check("R1 sample", int'(sample_tick), 0);
    check("R1 bit", int'(bit_tick), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      sync_mode = VECS[i][16];
      sp = int'(VECS[i][15:0]);
      bp = VECS[i][16] ? sp : 16 * sp;
      wr_psr(VECS[i][32:25]);
      check("R3 compat exit", int'(compat_mode), 0);
      wr_baud(VECS[i][24:17]);
      measure(bp > 2 * sp ? bp : 2 * sp);
      check("R4/R7 first sample", f1, sp);      // R4 R7 R10
      check("R4 second sample", f2, 2 * sp);    // R4
      if (VECS[i][16]) check("R6 sync bit", b1, bp);
      else             check("R5 async bit", b1, bp);
    end

    // R7: rewrite in mid period restarts counting
    sync_mode = 1'b0;
    wr_psr(8'h10);
    wr_baud(8'h02);
    repeat (5) @(negedge clk);
    wr_baud(8'h02);
    measure(12);
    check("R7 restart first sample", f1, 9);

    // R2: code zero enters compatibility mode and stays silent
    wr_psr(8'h00);
    check("R2 compat enter", int'(compat_mode), 1);
    wr_baud(8'h05);
    measure(300);
    check("R2 no sample in compat", f1, 0);
    check("R2 no bit in compat", b1, 0);
    // R3: leave again; divisor written during compat is used (C=1, D=5)
    wr_psr(8'h08);
    check("R3 compat exit", int'(compat_mode), 0);
    measure(14);
    check("R4 sample after compat", f1, 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule